// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits between a CPU write port and the controller of an embedded flash array. It watches CPU write events, each of which carries an address, a data byte and a set of sector-select lines. It picks out multi-write command sequences, each opened by a two-write unlock keyed on both address and data. For each recognised sequence it raises a one-cycle strobe toward the array controller. The commands are: enter protection-status mode, program one byte, erase a set of sectors, erase the whole array, suspend, resume and return to read mode.

The decoder keeps the block's operating mode. Sector erase has a collection window: each queued sector restarts a down-counter worth a fixed number of microseconds, and the erase launches when the counter runs out. While the block is in protection-status mode, a read of byte offset 02h in the selected sector returns that sector's protect bit instead of array data. A single `erase_done` input stands in for the array's erase timing.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, `mode` is 0 (read), every command strobe is low, `err_flag` is low and `erase_mask` is zero.
- R2: A command starts only after data AAh at address 555h and then data 55h at address AAAh. Only address bits 11..0 take part in this compare. A write that does not match the expected step returns the sequence to its start and issues no command.
- R3: After the unlock writes, a third write of 90h at 555h pulses `cmd_prot` and sets `mode` to 1 (protection status). In that mode, a read with `rd_offset` = 02h and exactly one `rd_sel` bit set returns 01h if that sector's `prot_bits` bit is 1 and 00h if it is 0. Any other read returns `array_rdata`.
- R4: After the unlock writes, a third write of A0h at 555h arms a program. The next write of any value at any address pulses `cmd_prog` with that write's address on `prog_addr` and its data on `prog_data`.
- R5: The sequence unlock, 80h at 555h, unlock, 10h at 555h pulses `cmd_bulk` and sets `mode` to 3 (erasing).
- R6: The same prefix ending in 30h with a nonzero `wr_sel` sets `mode` to 2 (collecting) and ORs `wr_sel` into `erase_mask`. While collecting, each further 30h write with a nonzero `wr_sel` adds to the mask and restarts the window. `cmd_erase` pulses, and `mode` becomes 3, exactly CYC_PER_US*WINDOW_US cycles after the last accepted add.
- R7: B0h at any address in mode 3 during a sector erase pulses `cmd_suspend` and sets `mode` to 4 (suspended). B0h during a bulk erase is an error.
- R8: In mode 4, 30h at any address (with no sequence in progress) pulses `cmd_resume` and returns `mode` to 3. A full program sequence is still accepted in mode 4 and leaves `mode` at 4.
- R9: In mode 2 or mode 3, any write other than those named in R6 and R7 sets `mode` to 5 (error). Mode 5 raises `err_flag` and forces bit 5 of `rd_data` high.
- R10: F0h at any address pulses `cmd_reset`, sets `mode` to 0 and clears `erase_mask`. This applies in modes 0, 1 and 5, but not to the data write of an armed program. F0h is the only way out of modes 1 and 5; every other write there has no effect.
- R11: `erase_done` in mode 3 returns `mode` to 0 and clears `erase_mask`.
- R12: In read mode, `rd_data` equals `array_rdata` with no unlock sequence needed.
- R13: At most one command strobe is high in any cycle, and each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One-cycle CPU write event |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| wr_sel | input | NSECT | Sector selects for the write |
| rd_offset | input | 8 | Low address byte of the current read |
| rd_sel | input | NSECT | Sector selects for the current read |
| array_rdata | input | 8 | Data read from the array |
| prot_bits | input | NSECT | Per-sector protect bits |
| erase_done | input | 1 | Array reports that the erase has finished |
| rd_data | output | 8 | Read data returned to the CPU |
| mode | output | 3 | Operating mode (0 read, 1 protection, 2 collecting, 3 erasing, 4 suspended, 5 error) |
| err_flag | output | 1 | Error mode indicator |
| cmd_prot | output | 1 | Strobe: enter protection-status mode |
| cmd_prog | output | 1 | Strobe: program one byte |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | 8 | Program data |
| cmd_erase | output | 1 | Strobe: start sector erase |
| erase_mask | output | NSECT | Sectors queued for erase |
| cmd_bulk | output | 1 | Strobe: start bulk erase |
| cmd_suspend | output | 1 | Strobe: suspend the erase |
| cmd_resume | output | 1 | Strobe: resume the erase |
| cmd_reset | output | 1 | Strobe: return to read mode |

## Verification
The hardest state to reach from the ports is a suspended sector erase whose mask holds several sectors and whose window was restarted partway through. To get there, the stimulus queues one sector and waits about a hundred cycles. It then adds a second sector and counts the cycles from that add to `cmd_erase`, then suspends. From the suspended state it runs a full program sequence and a resume. After that it sends a stray command, so that the error path is taken with a mask still pending.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        MODE_READ    = 3'd0,
        MODE_PROT    = 3'd1,
        MODE_WINDOW  = 3'd2,
        MODE_ERASING = 3'd3,
        MODE_SUSP    = 3'd4,
        MODE_ERROR   = 3'd5
    } fc_mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PROG,
        SQ_ERA1,
        SQ_ERA2,
        SQ_ERA3
    } fc_seq_e;

    typedef struct packed {
        logic s_prot;
        logic s_prog;
        logic s_erase;
        logic s_bulk;
        logic s_susp;
        logic s_resume;
        logic s_reset;
    } fc_strobe_t;

    localparam logic [11:0] KEY_ADR_A = 12'h555;
    localparam logic [11:0] KEY_ADR_B = 12'hAAA;

    localparam logic [7:0] D_UNLOCK1 = 8'hAA;
    localparam logic [7:0] D_UNLOCK2 = 8'h55;
    localparam logic [7:0] D_PROT    = 8'h90;
    localparam logic [7:0] D_PROG    = 8'hA0;
    localparam logic [7:0] D_ERASE   = 8'h80;
    localparam logic [7:0] D_BULK    = 8'h10;
    localparam logic [7:0] D_SECTOR  = 8'h30;
    localparam logic [7:0] D_SUSP    = 8'hB0;
    localparam logic [7:0] D_RESET   = 8'hF0;

    localparam logic [7:0] PROT_OFFSET = 8'h02;
    localparam int         ERR_BIT     = 5;

    function automatic logic key_match(input logic [11:0] a, input logic [7:0] d,
                                       input logic [11:0] ea, input logic [7:0] ed);
        return (a == ea) && (d == ed);
    endfunction

endpackage

// File: rtl/fcd_erase_window.sv
module fcd_erase_window
    import flash_cmd_pkg::*;
#(
    parameter int NSECT   = 8,
    parameter int WIN_CYC = 3200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             add,
    input  logic [NSECT-1:0] add_mask,
    input  logic             clear,
    output logic [NSECT-1:0] mask,
    output logic             expired
);
    localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (add) begin
            cnt <= CW'(WIN_CYC - 1);
        end else if (active && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            mask <= '0;
        end else if (add) begin
            mask <= mask | add_mask;
        end
    end

    assign expired = active && !add && (cnt == '0);

endmodule

// File: rtl/fcd_status_read.sv
module fcd_status_read
    import flash_cmd_pkg::*;
#(
    parameter int NSECT = 8
) (
    input  fc_mode_e         mode,
    input  logic [7:0]       rd_offset,
    input  logic [NSECT-1:0] rd_sel,
    input  logic [7:0]       array_rdata,
    input  logic [NSECT-1:0] prot_bits,
    output logic [7:0]       rd_data
);
    logic sel_single;
    logic prot_read;

    assign sel_single = (rd_sel != '0) && ((rd_sel & (rd_sel - 1'b1)) == '0);
    assign prot_read  = (mode == MODE_PROT) && (rd_offset == PROT_OFFSET) && sel_single;

    always_comb begin
        if (prot_read) begin
            rd_data = {7'd0, |(rd_sel & prot_bits)};
        end else begin
            rd_data = array_rdata;
        end
        if (mode == MODE_ERROR) begin
            rd_data[ERR_BIT] = 1'b1;
        end
    end

endmodule

// File: rtl/fcd_sequencer.sv
module fcd_sequencer
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NSECT  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [NSECT-1:0]  wr_sel,
    input  logic              win_expired,
    input  logic              erase_done,
    output fc_mode_e          mode,
    output fc_strobe_t        stb,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              sect_add,
    output logic              mask_clear
);
    fc_seq_e     seq;
    logic        bulk_run;
    logic [11:0] low;
    logic        hit_u1, hit_u2, hit_prot, hit_prog, hit_era, hit_bulk;
    logic        reset_hit, done_hit;

    assign low      = wr_addr[11:0];
    assign hit_u1   = key_match(low, wr_data, KEY_ADR_A, D_UNLOCK1);
    assign hit_u2   = key_match(low, wr_data, KEY_ADR_B, D_UNLOCK2);
    assign hit_prot = key_match(low, wr_data, KEY_ADR_A, D_PROT);
    assign hit_prog = key_match(low, wr_data, KEY_ADR_A, D_PROG);
    assign hit_era  = key_match(low, wr_data, KEY_ADR_A, D_ERASE);
    assign hit_bulk = key_match(low, wr_data, KEY_ADR_A, D_BULK);

    assign reset_hit = wr_valid && (wr_data == D_RESET) &&
                       ((mode == MODE_PROT) || (mode == MODE_ERROR) ||
                        ((mode == MODE_READ) && (seq != SQ_PROG)));
    assign sect_add  = wr_valid && (wr_data == D_SECTOR) && (wr_sel != '0) &&
                       ((mode == MODE_WINDOW) || ((mode == MODE_READ) && (seq == SQ_ERA3)));
    assign done_hit  = erase_done && (mode == MODE_ERASING);
    assign mask_clear = reset_hit || done_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= MODE_READ;
            seq       <= SQ_IDLE;
            bulk_run  <= 1'b0;
            stb       <= '0;
            prog_addr <= '0;
            prog_data <= '0;
        end else begin
            stb <= '0;
            if (done_hit) begin
                mode <= MODE_READ;
            end
            if (win_expired && !wr_valid) begin
                stb.s_erase <= 1'b1;
                mode        <= MODE_ERASING;
            end
            if (wr_valid) begin
                if (reset_hit) begin
                    stb.s_reset <= 1'b1;
                    mode        <= MODE_READ;
                    seq         <= SQ_IDLE;
                end else begin
                    case (mode)
                        MODE_WINDOW: begin
                            if (!sect_add) mode <= MODE_ERROR;
                        end
                        MODE_ERASING: begin
                            if (wr_data == D_SUSP && !bulk_run) begin
                                stb.s_susp <= 1'b1;
                                mode       <= MODE_SUSP;
                            end else begin
                                mode <= MODE_ERROR;
                            end
                        end
                        MODE_PROT, MODE_ERROR: begin
                        end
                        default: begin
                            case (seq)
                                SQ_IDLE: begin
                                    if (hit_u1) begin
                                        seq <= SQ_UNL1;
                                    end else if (mode == MODE_SUSP && wr_data == D_SECTOR) begin
                                        stb.s_resume <= 1'b1;
                                        mode         <= MODE_ERASING;
                                    end
                                end
                                SQ_UNL1: seq <= hit_u2 ? SQ_UNL2 : SQ_IDLE;
                                SQ_UNL2: begin
                                    seq <= SQ_IDLE;
                                    if (hit_prog) begin
                                        seq <= SQ_PROG;
                                    end else if (mode == MODE_READ && hit_prot) begin
                                        stb.s_prot <= 1'b1;
                                        mode       <= MODE_PROT;
                                    end else if (mode == MODE_READ && hit_era) begin
                                        seq <= SQ_ERA1;
                                    end
                                end
                                SQ_PROG: begin
                                    stb.s_prog <= 1'b1;
                                    prog_addr  <= wr_addr;
                                    prog_data  <= wr_data;
                                    seq        <= SQ_IDLE;
                                end
                                SQ_ERA1: seq <= hit_u1 ? SQ_ERA2 : SQ_IDLE;
                                SQ_ERA2: seq <= hit_u2 ? SQ_ERA3 : SQ_IDLE;
                                SQ_ERA3: begin
                                    seq <= SQ_IDLE;
                                    if (hit_bulk) begin
                                        stb.s_bulk <= 1'b1;
                                        bulk_run   <= 1'b1;
                                        mode       <= MODE_ERASING;
                                    end else if (sect_add) begin
                                        bulk_run <= 1'b0;
                                        mode     <= MODE_WINDOW;
                                    end
                                end
                                default: seq <= SQ_IDLE;
                            endcase
                        end
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NSECT      = 8,
    parameter int CYC_PER_US = 40,
    parameter int WINDOW_US  = 80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [NSECT-1:0]  wr_sel,
    input  logic [7:0]        rd_offset,
    input  logic [NSECT-1:0]  rd_sel,
    input  logic [7:0]        array_rdata,
    input  logic [NSECT-1:0]  prot_bits,
    input  logic              erase_done,
    output logic [7:0]        rd_data,
    output logic [2:0]        mode,
    output logic              err_flag,
    output logic              cmd_prot,
    output logic              cmd_prog,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              cmd_erase,
    output logic [NSECT-1:0]  erase_mask,
    output logic              cmd_bulk,
    output logic              cmd_suspend,
    output logic              cmd_resume,
    output logic              cmd_reset
);
    localparam int WIN_CYC = CYC_PER_US * WINDOW_US;

    fc_mode_e   mode_q;
    fc_strobe_t stb;
    logic       sect_add, mask_clear, win_expired;

    fcd_sequencer #(.ADDR_W(ADDR_W), .NSECT(NSECT)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_sel      (wr_sel),
        .win_expired (win_expired),
        .erase_done  (erase_done),
        .mode        (mode_q),
        .stb         (stb),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .sect_add    (sect_add),
        .mask_clear  (mask_clear)
    );

    fcd_erase_window #(.NSECT(NSECT), .WIN_CYC(WIN_CYC)) u_win (
        .clk      (clk),
        .rst      (rst),
        .active   (mode_q == MODE_WINDOW),
        .add      (sect_add),
        .add_mask (wr_sel),
        .clear    (mask_clear),
        .mask     (erase_mask),
        .expired  (win_expired)
    );

    fcd_status_read #(.NSECT(NSECT)) u_rd (
        .mode        (mode_q),
        .rd_offset   (rd_offset),
        .rd_sel      (rd_sel),
        .array_rdata (array_rdata),
        .prot_bits   (prot_bits),
        .rd_data     (rd_data)
    );

    assign mode        = mode_q;
    assign err_flag    = (mode_q == MODE_ERROR);
    assign cmd_prot    = stb.s_prot;
    assign cmd_prog    = stb.s_prog;
    assign cmd_erase   = stb.s_erase;
    assign cmd_bulk    = stb.s_bulk;
    assign cmd_suspend = stb.s_susp;
    assign cmd_resume  = stb.s_resume;
    assign cmd_reset   = stb.s_reset;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int NSECT = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       mode,
    input logic             err_flag,
    input logic [7:0]       rd_data,
    input logic             cmd_prot,
    input logic             cmd_prog,
    input logic             cmd_erase,
    input logic [NSECT-1:0] erase_mask,
    input logic             cmd_bulk,
    input logic             cmd_suspend,
    input logic             cmd_resume,
    input logic             cmd_reset
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_prot, cmd_prog, cmd_erase, cmd_bulk, cmd_suspend, cmd_resume, cmd_reset})); // R13

    AST_PROG_PULSE: assert property (@(posedge clk) disable iff (rst)
        cmd_prog |=> !cmd_prog); // R13

    AST_ERASE_HAS_SECTORS: assert property (@(posedge clk) disable iff (rst)
        cmd_erase |-> (erase_mask != '0)); // R6

    AST_ERASE_FROM_WINDOW: assert property (@(posedge clk) disable iff (rst)
        cmd_erase |-> ($past(mode) == 3'd2 && mode == 3'd3)); // R6

    AST_SUSPEND_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cmd_suspend |-> ($past(mode) == 3'd3 && mode == 3'd4)); // R7

    AST_RESUME_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cmd_resume |-> ($past(mode) == 3'd4 && mode == 3'd3)); // R8

    AST_ERR_ON_DQ5: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> rd_data[5]); // R9

    AST_STICKY_EXIT: assert property (@(posedge clk) disable iff (rst)
        (($past(mode) == 3'd1 || $past(mode) == 3'd5) && mode != $past(mode)) |-> cmd_reset); // R10

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cmd_reset |-> (mode == 3'd0 && erase_mask == '0)); // R10

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.NSECT(NSECT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .err_flag    (err_flag),
    .rd_data     (rd_data),
    .cmd_prot    (cmd_prot),
    .cmd_prog    (cmd_prog),
    .cmd_erase   (cmd_erase),
    .erase_mask  (erase_mask),
    .cmd_bulk    (cmd_bulk),
    .cmd_suspend (cmd_suspend),
    .cmd_resume  (cmd_resume),
    .cmd_reset   (cmd_reset)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int NSECT      = 8;
    localparam int CPU        = 40;
    localparam int WUS        = 80;
    localparam int WIN        = CPU * WUS;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [NSECT-1:0]  wr_sel;
    logic [7:0]        rd_offset;
    logic [NSECT-1:0]  rd_sel;
    logic [7:0]        array_rdata;
    logic [NSECT-1:0]  prot_bits;
    logic              erase_done;
    logic [7:0]        rd_data;
    logic [2:0]        mode;
    logic              err_flag;
    logic              cmd_prot, cmd_prog, cmd_erase, cmd_bulk;
    logic              cmd_suspend, cmd_resume, cmd_reset;
    logic [ADDR_W-1:0] prog_addr;
    logic [7:0]        prog_data;
    logic [NSECT-1:0]  erase_mask;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(ADDR_W), .NSECT(NSECT), .CYC_PER_US(CPU), .WINDOW_US(WUS)) u_flash_cmd_decoder (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_sel(wr_sel), .rd_offset(rd_offset), .rd_sel(rd_sel), .array_rdata(array_rdata),
        .prot_bits(prot_bits), .erase_done(erase_done), .rd_data(rd_data), .mode(mode),
        .err_flag(err_flag), .cmd_prot(cmd_prot), .cmd_prog(cmd_prog), .prog_addr(prog_addr),
        .prog_data(prog_data), .cmd_erase(cmd_erase), .erase_mask(erase_mask), .cmd_bulk(cmd_bulk),
        .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .cmd_reset(cmd_reset)
    );

    // strobe vector: prot, prog, erase, bulk, suspend, resume, reset
    function automatic logic [6:0] strobes();
        return {cmd_prot, cmd_prog, cmd_erase, cmd_bulk, cmd_suspend, cmd_resume, cmd_reset};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [NSECT-1:0] s);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_sel = s;
        @(negedge clk);
        wr_valid = 1'b0; wr_sel = '0;
    endtask

    task automatic unlock();
        wr(16'h0555, 8'hAA, '0);
        wr(16'h0AAA, 8'h55, '0);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(16'h0555, 8'h80, '0);
        unlock();
    endtask

    task automatic do_reset();
        wr(16'h0000, 8'hF0, '0);
    endtask

    task automatic t_reset_state();
        check("R1 mode", 32'(mode), 0);
        check("R1 strobes", 32'(strobes()), 0);
        check("R1 err_flag", 32'(err_flag), 0);
        check("R1 erase_mask", 32'(erase_mask), 0);
    endtask

    task automatic t_read_pass();
        array_rdata = 8'h5A; rd_offset = 8'h02; rd_sel = 8'h01;
        #1 check("R12 read passthrough", 32'(rd_data), 32'h5A);
    endtask

    task automatic t_unlock();
        wr(16'h0555, 8'hAA, '0);
        wr(16'h0AAA, 8'h54, '0);
        wr(16'h0555, 8'h90, '0);
        check("R2 mismatch no command", 32'(strobes()), 0);
        check("R2 mismatch stays read", 32'(mode), 0);
        wr(16'hF555, 8'hAA, '0);
        wr(16'h3AAA, 8'h55, '0);
        wr(16'h7555, 8'h90, '0);
        check("R2 R3 prot strobe", 32'(strobes()), 32'b1000000);
        check("R3 prot mode", 32'(mode), 1);
    endtask

    task automatic t_prot();
        prot_bits = 8'b0000_0100; array_rdata = 8'hC7;
        rd_offset = 8'h02; rd_sel = 8'h04;
        #1 check("R3 protected sector", 32'(rd_data), 32'h01);
        rd_sel = 8'h02;
        #1 check("R3 unprotected sector", 32'(rd_data), 32'h00);
        rd_offset = 8'h03;
        #1 check("R3 other offset", 32'(rd_data), 32'hC7);
        unlock();
        wr(16'h0555, 8'hA0, '0);
        wr(16'h0100, 8'h11, '0);
        check("R10 prot ignores writes", 32'(mode), 1);
        do_reset();
        check("R10 reset strobe", 32'(strobes()), 32'b0000001);
        check("R10 back to read", 32'(mode), 0);
    endtask

    task automatic t_program();
        unlock();
        wr(16'h0555, 8'hA0, '0);
        wr(16'h1234, 8'hF0, '0);
        check("R4 prog strobe", 32'(strobes()), 32'b0100000);
        check("R4 prog addr", 32'(prog_addr), 32'h1234);
        check("R4 prog data", 32'(prog_data), 32'hF0);
        check("R4 mode", 32'(mode), 0);
        @(negedge clk);
        check("R13 strobe one cycle", 32'(strobes()), 0);
    endtask

    task automatic t_bulk();
        erase_prefix();
        wr(16'h0555, 8'h10, '0);
        check("R5 bulk strobe", 32'(strobes()), 32'b0001000);
        check("R5 erasing", 32'(mode), 3);
        wr(16'h0000, 8'hB0, '0);
        check("R7 suspend in bulk is error", 32'(mode), 5);
        check("R7 no suspend strobe", 32'(strobes()), 0);
        array_rdata = 8'h00; rd_offset = 8'h00;
        #1 check("R9 dq5", 32'(rd_data), 32'h20);
        check("R9 err_flag", 32'(err_flag), 1);
        wr(16'h0555, 8'hAA, '0);
        erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
        check("R10 error sticky", 32'(mode), 5);
        do_reset();
        check("R10 error exit", 32'(mode), 0);
        erase_prefix();
        wr(16'h0555, 8'h10, '0);
        erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
        check("R11 done returns read", 32'(mode), 0);
    endtask

    task automatic t_sector();
        int k;
        erase_prefix();
        wr(16'h0800, 8'h30, 8'h01);
        check("R6 collecting", 32'(mode), 2);
        check("R6 mask first", 32'(erase_mask), 32'h01);
        repeat (100) @(negedge clk);
        wr(16'h0C00, 8'h30, 8'h10);
        check("R6 mask second", 32'(erase_mask), 32'h11);
        k = 0;
        while (!cmd_erase && k < 2*WIN) begin
            @(negedge clk);
            k++;
        end
        check("R6 window length", 32'(k), 32'(WIN));
        check("R6 erase mask", 32'(erase_mask), 32'h11);
        check("R6 erasing", 32'(mode), 3);
        wr(16'h4321, 8'hB0, '0);
        check("R7 suspend strobe", 32'(strobes()), 32'b0000100);
        check("R7 suspended", 32'(mode), 4);
        unlock();
        wr(16'h0555, 8'hA0, '0);
        wr(16'h0042, 8'h99, '0);
        check("R8 program while suspended", 32'(strobes()), 32'b0100000);
        check("R8 still suspended", 32'(mode), 4);
        wr(16'h0777, 8'h30, '0);
        check("R8 resume strobe", 32'(strobes()), 32'b0000010);
        check("R8 erasing again", 32'(mode), 3);
        wr(16'h0555, 8'h90, '0);
        check("R9 stray command", 32'(mode), 5);
        do_reset();
        check("R10 mask cleared", 32'(erase_mask), 0);
        erase_prefix();
        wr(16'h0800, 8'h30, 8'h04);
        wr(16'h0555, 8'h55, '0);
        check("R9 stray in window", 32'(mode), 5);
        do_reset();
        erase_prefix();
        wr(16'h0800, 8'h30, 8'h02);
        repeat (WIN + 2) @(negedge clk);
        check("R6 single erase", 32'(mode), 3);
        erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
        check("R11 done read", 32'(mode), 0);
        check("R11 mask cleared", 32'(erase_mask), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; wr_sel = '0;
        rd_offset = '0; rd_sel = '0; array_rdata = '0; prot_bits = '0; erase_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_read_pass();
        t_unlock();
        t_prot();
        t_program();
        t_bulk();
        t_sector();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule